// File: doc/BRIEF.md
# Single-Level Interrupt Controller

This block handles interrupts for a small 12-bit processor that has one interrupt level. The devices' requests are ORed outside the block into one level-sensitive line. The block samples that line only when the processor signals an instruction boundary. If interrupts are enabled at that moment, the block forces a subroutine call to location 0. It writes the return address into word 0 and loads the program counter with 1. Taking the interrupt turns the enable off. The only way to turn it back on is the I/O instruction octal 6001.

The enable set by that instruction is held back by one instruction. This lets the return, an indirect jump through location 0 (octal 5200), finish before the next interrupt can be taken. The block also flags each completed return jump. Device priority and polling are left to software.

Top module: `single_irq_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, the enable is off. In that cycle no strobe (`irq_taken_o`, `vec_we_o`, `pc_load_o`, `ret_seen_o`) is high.
- R2: When the enable is off and no enable is armed, a boundary with `irq_req_i` high takes no interrupt.
- R3: An interrupt is taken on a clock edge that samples `instr_done_i` and `irq_req_i` both high while interrupts are enabled. In the cycle after that edge, `irq_taken_o`, `vec_we_o` and `pc_load_o` are high for exactly one cycle. In that cycle `vec_addr_o` is 0, `vec_data_o` equals the sampled `next_pc_i`, and `pc_value_o` is 1.
- R4: Taking an interrupt turns the enable off. It also cancels any enable armed by octal 6001 at the same boundary or earlier.
- R5: Completing octal 6001 (hex C01) arms the enable, but `irq_enabled_o` stays low after that boundary. At the next boundary the enable is already in force, so an interrupt can be taken there. After that boundary `irq_enabled_o` is high unless an interrupt was taken.
- R6: Completing octal 5200 (hex A80) at a boundary raises `ret_seen_o` for the one following cycle.
- R7: While `instr_done_i` is low, `irq_req_i`, `cur_instr_i` and `next_pc_i` have no effect: no interrupt is taken and the enable does not change.
- R8: At a boundary, any instruction other than octal 6001 leaves the enable unchanged, except when an interrupt is taken or a pending arm matures. Octal 6001 completed while the enable is on leaves it on.
- R9: Requests are not remembered. A request that drops before the next boundary leads to no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req_i | input | 1 | OR of all device interrupt requests, level-sensitive |
| instr_done_i | input | 1 | High for one cycle when an instruction completes |
| cur_instr_i | input | 12 | Instruction that is completing at the boundary |
| next_pc_i | input | 12 | Address of the next instruction, used as the return address |
| irq_taken_o | output | 1 | One-cycle pulse: an interrupt was taken |
| vec_we_o | output | 1 | Write strobe for storing the return address |
| vec_addr_o | output | 12 | Write address, always location 0 when the strobe is high |
| vec_data_o | output | 12 | Return address being stored |
| pc_load_o | output | 1 | Program counter load strobe |
| pc_value_o | output | 12 | New program counter value, location 1 |
| ret_seen_o | output | 1 | One-cycle pulse: an indirect return through location 0 completed |
| irq_enabled_o | output | 1 | Interrupt enable currently in force |

## Verification
The enable state machine has only three states, and each wrong state shows up at the ports within one boundary. A controller stuck off misses a request that should be taken in the cycle after the boundary. One that skips the armed step shows `irq_enabled_o` high right after octal 6001, or takes an interrupt at that same boundary. A controller that keeps the arm through a taken interrupt shows the enable coming back on at the next boundary, without a new 6001.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

    localparam int WORD_W = 12;

    typedef logic [WORD_W-1:0] word_t;

    // Instruction codes recognised at a boundary
    localparam word_t ENABLE_CODE = 12'o6001;
    localparam word_t RETURN_CODE = 12'o5200;
    localparam word_t VECTOR_LOC  = 12'o0000;

    typedef enum logic [1:0] {
        CLS_OTHER  = 2'd0,
        CLS_ENABLE = 2'd1,
        CLS_RETURN = 2'd2
    } op_class_e;

    // Enable state: OFF, armed (on after the next instruction), ON
    typedef enum logic [1:0] {
        EN_OFF   = 2'd0,
        EN_ARMED = 2'd1,
        EN_ON    = 2'd2
    } en_state_e;

    typedef struct packed {
        logic      boundary;
        logic      req;
        op_class_e cls;
        word_t     ret_addr;
    } boundary_t;

    typedef struct packed {
        logic  we;
        word_t addr;
        word_t data;
        logic  pc_load;
        word_t pc_val;
        logic  ret_seen;
    } call_t;

    function automatic op_class_e classify(word_t w, word_t en_code, word_t ret_code);
        if (w == en_code)
            return CLS_ENABLE;
        else if (w == ret_code)
            return CLS_RETURN;
        else
            return CLS_OTHER;
    endfunction

endpackage

// File: rtl/sirq_decode.sv
module sirq_decode
    import sirq_pkg::*;
#(
    parameter word_t EN_CODE  = ENABLE_CODE,
    parameter word_t RET_CODE = RETURN_CODE
) (
    input  logic      instr_done,
    input  logic      req,
    input  word_t     instr,
    input  word_t     next_pc,
    output boundary_t bnd
);

    always_comb begin
        bnd.boundary = instr_done;
        bnd.req      = instr_done & req;
        bnd.cls      = instr_done ? classify(instr, EN_CODE, RET_CODE) : CLS_OTHER;
        bnd.ret_addr = next_pc;
    end

endmodule

// File: rtl/sirq_enable_ctl.sv
module sirq_enable_ctl
    import sirq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  boundary_t bnd,
    output logic      take,
    output logic      enabled
);

    en_state_e st_q, st_d;
    logic      en_eff;

    // An armed enable is already in force at the boundary after 6001
    assign en_eff = (st_q != EN_OFF);
    assign take   = bnd.boundary & bnd.req & en_eff;

    always_comb begin
        st_d = st_q;
        if (bnd.boundary) begin
            if (take)
                st_d = EN_OFF;
            else if (bnd.cls == CLS_ENABLE)
                st_d = (st_q == EN_ON) ? EN_ON : EN_ARMED;
            else if (st_q == EN_ARMED)
                st_d = EN_ON;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= EN_OFF;
        else
            st_q <= st_d;
    end

    assign enabled = (st_q == EN_ON);

    // R1: reset leaves the state off
    p_reset_off_r1: assert property (@(posedge clk)
        $past(rst) |-> (st_q == EN_OFF));

    // R8: state holds between boundaries
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !bnd.boundary |=> $stable(st_q));

    // R2: without a 6001 the state cannot climb out of off
    p_off_stays_r2: assert property (@(posedge clk) disable iff (rst)
        (st_q == EN_OFF && bnd.cls != CLS_ENABLE) |=> (st_q == EN_OFF));

    // R5: a 6001 completed while off never jumps straight to on
    p_arm_first_r5: assert property (@(posedge clk) disable iff (rst)
        (st_q == EN_OFF && bnd.boundary && bnd.cls == CLS_ENABLE) |=> (st_q == EN_ARMED));

endmodule

// File: rtl/sirq_call_gen.sv
module sirq_call_gen
    import sirq_pkg::*;
#(
    parameter word_t VEC = VECTOR_LOC
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      take,
    input  boundary_t bnd,
    output call_t     call
);

    localparam word_t ENTRY = VEC + word_t'(1);

    call_t call_d;

    always_comb begin
        call_d          = '0;
        call_d.ret_seen = bnd.boundary && (bnd.cls == CLS_RETURN);
        if (take) begin
            call_d.we      = 1'b1;
            call_d.addr    = VEC;
            call_d.data    = bnd.ret_addr;
            call_d.pc_load = 1'b1;
            call_d.pc_val  = ENTRY;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            call <= '0;
        else
            call <= call_d;
    end

    // R3: the store and the load always come together
    p_store_with_load_r3: assert property (@(posedge clk) disable iff (rst)
        call.we |-> (call.pc_load && call.addr == VEC && call.pc_val == ENTRY));

endmodule

// File: rtl/single_irq_ctrl.sv
module single_irq_ctrl
    import sirq_pkg::*;
#(
    parameter word_t VEC      = VECTOR_LOC,
    parameter word_t EN_CODE  = ENABLE_CODE,
    parameter word_t RET_CODE = RETURN_CODE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              irq_req_i,
    input  logic              instr_done_i,
    input  logic [WORD_W-1:0] cur_instr_i,
    input  logic [WORD_W-1:0] next_pc_i,
    output logic              irq_taken_o,
    output logic              vec_we_o,
    output logic [WORD_W-1:0] vec_addr_o,
    output logic [WORD_W-1:0] vec_data_o,
    output logic              pc_load_o,
    output logic [WORD_W-1:0] pc_value_o,
    output logic              ret_seen_o,
    output logic              irq_enabled_o
);

    boundary_t bnd;
    logic      take;
    call_t     call;

    sirq_decode #(
        .EN_CODE  (EN_CODE),
        .RET_CODE (RET_CODE)
    ) decode_i (
        .instr_done (instr_done_i),
        .req        (irq_req_i),
        .instr      (cur_instr_i),
        .next_pc    (next_pc_i),
        .bnd        (bnd)
    );

    sirq_enable_ctl enable_i (
        .clk     (clk),
        .rst     (rst),
        .bnd     (bnd),
        .take    (take),
        .enabled (irq_enabled_o)
    );

    sirq_call_gen #(
        .VEC (VEC)
    ) call_i (
        .clk  (clk),
        .rst  (rst),
        .take (take),
        .bnd  (bnd),
        .call (call)
    );

    assign irq_taken_o = call.we;
    assign vec_we_o    = call.we;
    assign vec_addr_o  = call.addr;
    assign vec_data_o  = call.data;
    assign pc_load_o   = call.pc_load;
    assign pc_value_o  = call.pc_val;
    assign ret_seen_o  = call.ret_seen;

    // R7: an interrupt follows only a sampled boundary with a request
    p_take_at_boundary_r7: assert property (@(posedge clk) disable iff (rst)
        irq_taken_o |-> $past(instr_done_i && irq_req_i));

    // R4: taking an interrupt leaves the enable off
    p_take_clears_r4: assert property (@(posedge clk) disable iff (rst)
        irq_taken_o |-> !irq_enabled_o);

    // R3: the forced call is a single-cycle pulse
    p_take_once_r3: assert property (@(posedge clk) disable iff (rst)
        irq_taken_o |=> !irq_taken_o);

    // R3: the stored word is the return address
    p_ret_addr_r3: assert property (@(posedge clk) disable iff (rst)
        vec_we_o |-> (vec_data_o == $past(next_pc_i)));

    // R5: the enable rises only after a boundary
    p_enable_rise_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_enabled_o) |-> $past(instr_done_i));

    // R6: return flag follows a boundary
    p_ret_flag_r6: assert property (@(posedge clk) disable iff (rst)
        ret_seen_o |-> $past(instr_done_i));

endmodule

// File: tb/single_irq_ctrl_tb.sv
module single_irq_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        irq_req;
    logic        instr_done;
    logic [11:0] cur_instr;
    logic [11:0] next_pc;
    logic        irq_taken;
    logic        vec_we;
    logic [11:0] vec_addr;
    logic [11:0] vec_data;
    logic        pc_load;
    logic [11:0] pc_value;
    logic        ret_seen;
    logic        irq_enabled;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    single_irq_ctrl dut_i (
        .clk           (clk),
        .rst           (rst),
        .irq_req_i     (irq_req),
        .instr_done_i  (instr_done),
        .cur_instr_i   (cur_instr),
        .next_pc_i     (next_pc),
        .irq_taken_o   (irq_taken),
        .vec_we_o      (vec_we),
        .vec_addr_o    (vec_addr),
        .vec_data_o    (vec_data),
        .pc_load_o     (pc_load),
        .pc_value_o    (pc_value),
        .ret_seen_o    (ret_seen),
        .irq_enabled_o (irq_enabled)
    );

    typedef struct packed {
        logic        done;
        logic        req;
        logic [11:0] instr;
        logic [11:0] pc;
        logic        e_take;
        logic        e_ret;
        logic        e_en;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b1, 12'o7000, 12'o0100, 1'b0, 1'b0, 1'b0}, // 0  R2 off ignores request
        '{1'b1, 1'b1, 12'o6001, 12'o0101, 1'b0, 1'b0, 1'b0}, // 1  R5 armed, not yet on
        '{1'b1, 1'b0, 12'o5200, 12'o0102, 1'b0, 1'b1, 1'b1}, // 2  R5 R6 on after next
        '{1'b0, 1'b1, 12'o1234, 12'o0103, 1'b0, 1'b0, 1'b1}, // 3  R7 no boundary
        '{1'b1, 1'b0, 12'o1234, 12'o0104, 1'b0, 1'b0, 1'b1}, // 4  R8 other code
        '{1'b1, 1'b1, 12'o1234, 12'o0200, 1'b1, 1'b0, 1'b0}, // 5  R3 R4 take
        '{1'b1, 1'b1, 12'o6001, 12'o0002, 1'b0, 1'b0, 1'b0}, // 6  R5 6001 own boundary
        '{1'b1, 1'b1, 12'o5200, 12'o0300, 1'b1, 1'b1, 1'b0}, // 7  R5 take right after return
        '{1'b1, 1'b0, 12'o6001, 12'o0301, 1'b0, 1'b0, 1'b0}, // 8  R5 arm
        '{1'b1, 1'b0, 12'o7000, 12'o0302, 1'b0, 1'b0, 1'b1}, // 9  R5 on
        '{1'b1, 1'b0, 12'o6001, 12'o0303, 1'b0, 1'b0, 1'b1}, // 10 R8 6001 while on
        '{1'b1, 1'b1, 12'o6001, 12'o0400, 1'b1, 1'b0, 1'b0}, // 11 R4 take over 6001
        '{1'b1, 1'b0, 12'o7000, 12'o0001, 1'b0, 1'b0, 1'b0}, // 12 R4 arm cancelled
        '{1'b1, 1'b0, 12'o6001, 12'o0002, 1'b0, 1'b0, 1'b0}, // 13 R5 arm
        '{1'b1, 1'b0, 12'o7000, 12'o0003, 1'b0, 1'b0, 1'b1}, // 14 R5 on
        '{1'b0, 1'b1, 12'o7000, 12'o0004, 1'b0, 1'b0, 1'b1}, // 15 R9 request between boundaries
        '{1'b1, 1'b0, 12'o7000, 12'o0005, 1'b0, 1'b0, 1'b1}, // 16 R9 dropped, not taken
        '{1'b1, 1'b1, 12'o7000, 12'o0777, 1'b1, 1'b0, 1'b0}  // 17 R3 take
    };

    function automatic string vtag(int i);
        case (i)
            0:           return "R2";
            3:           return "R7";
            4, 10:       return "R8";
            5, 17:       return "R3";
            11, 12:      return "R4";
            15, 16:      return "R9";
            2:           return "R6";
            default:     return "R5";
        endcase
    endfunction

    task automatic chk(string req, string what, logic [11:0] act, logic [11:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive(logic d, logic r, logic [11:0] ins, logic [11:0] pc);
        instr_done = d;
        irq_req    = r;
        cur_instr  = ins;
        next_pc    = pc;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        drive(1'b0, 1'b0, 12'o0, 12'o0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: state after reset
        chk("R1", "enable after reset", 12'(irq_enabled), 12'd0);
        chk("R1", "strobes after reset", {8'd0, irq_taken, vec_we, pc_load, ret_seen}, 12'd0);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].done, VECS[i].req, VECS[i].instr, VECS[i].pc);
            @(negedge clk);
            chk(vtag(i), $sformatf("v%0d take", i), 12'(irq_taken), 12'(VECS[i].e_take));
            chk(vtag(i), $sformatf("v%0d ret flag", i), 12'(ret_seen), 12'(VECS[i].e_ret));
            chk(vtag(i), $sformatf("v%0d enable", i), 12'(irq_enabled), 12'(VECS[i].e_en));
            chk(vtag(i), $sformatf("v%0d we/load", i), {10'd0, vec_we, pc_load},
                {10'd0, VECS[i].e_take, VECS[i].e_take});
            if (VECS[i].e_take) begin
                chk("R3", $sformatf("v%0d store addr", i), vec_addr, 12'o0000);
                chk("R3", $sformatf("v%0d store data", i), vec_data, VECS[i].pc);
                chk("R3", $sformatf("v%0d new pc", i), pc_value, 12'o0001);
            end
        end

        // R3: the forced-call pulse lasts one cycle
        drive(1'b0, 1'b1, 12'o7000, 12'o0010);
        @(negedge clk);
        chk("R3", "pulse width", {9'd0, irq_taken, vec_we, pc_load}, 12'd0);

        // R1: reset in mid-operation clears an active enable
        drive(1'b1, 1'b0, 12'o6001, 12'o0011);
        @(negedge clk);
        drive(1'b1, 1'b0, 12'o7000, 12'o0012);
        @(negedge clk);
        chk("R1", "enable on before reset", 12'(irq_enabled), 12'd1);
        rst = 1'b1;
        drive(1'b1, 1'b1, 12'o5200, 12'o0013);
        @(negedge clk);
        rst = 1'b0;
        drive(1'b0, 1'b0, 12'o7000, 12'o0014);
        @(negedge clk);
        chk("R1", "enable after mid reset", 12'(irq_enabled), 12'd0);
        chk("R1", "strobes after mid reset", {8'd0, irq_taken, vec_we, pc_load, ret_seen}, 12'd0);

        // R2: after reset a request at a boundary is not taken
        drive(1'b1, 1'b1, 12'o7000, 12'o0015);
        @(negedge clk);
        chk("R2", "no take after reset", 12'(irq_taken), 12'd0);

        drive(1'b0, 1'b0, 12'o0, 12'o0);
        @(negedge clk);
        finish_run();
    end

endmodule